// File: doc/BRIEF.md
# Attempt-Subtraction Array Divider

This block divides an unsigned dividend by an unsigned divisor in a single pass through a matrix of one-bit controlled subtract-multiplex cells. There is one row of cells for each dividend bit. Each row shifts the next dividend bit, starting from the most significant, into the partial remainder. The row then tries to subtract the divisor. If the row's final borrow shows that the result would be negative, every cell in that row passes its minuend through unchanged. In either case the inverted borrow becomes one quotient bit.

The matrix has no clock. An optional register stage, enabled by default, captures the quotient and the remainder so that the long borrow path can be timed against a clock. The worst path through the matrix is taken when every row cancels its subtraction. A zero divisor is not flagged. It gives a defined result: the quotient is all ones and the remainder is the low part of the dividend.

Top module: `array_divider`

## Requirements
- R1: For a nonzero divisor, `quotient_o` equals the dividend divided by the divisor, rounded down.
- R2: For a nonzero divisor, `remainder_o` equals the dividend modulo the divisor, so it is always smaller than the divisor.
- R3: For a zero divisor, every bit of `quotient_o` is 1.
- R4: For a zero divisor, `remainder_o` equals the dividend's low `Y_W+1` bits (bits `Y_W` down to 0). This needs `X_W > Y_W`.
- R5: With `REG_OUT=1`, both results reflect the operands present at a rising edge of `clk_i`. They appear just after that edge. Operand changes between edges leave the outputs unchanged until the next rising edge.
- R6: With `REG_OUT=1`, while `rst_ni` is low both outputs are zero, whatever the operands. Reset takes effect without waiting for a clock edge.
- R7: A dividend smaller than a nonzero divisor gives a quotient of 0 and a remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| dividend_i | input | X_W | Unsigned dividend |
| divisor_i | input | Y_W | Unsigned divisor |
| quotient_o | output | X_W | Quotient, one bit per matrix row |
| remainder_o | output | Y_W+1 | Remainder taken from the last row of the matrix |

## Verification
Both results are due one rising edge after the operands are applied. The bench drives operands on a falling edge and checks them on the next falling edge, which is half a period after the capturing edge. For R5 it also samples just after a mid-cycle operand change and expects the previous results to be unchanged. Reset is asynchronous, so the R6 check is made one time unit after `rst_ni` falls, with no clock edge in between. The sweep covers every pair of 8-bit dividend and 4-bit divisor, and each result is compared against integer division and modulo computed in the bench.

// File: rtl/div_pkg.sv
package div_pkg;
  // operand bundle of one subtract-multiplex cell
  typedef struct packed {
    logic x;   // minuend bit
    logic y;   // subtrahend bit
    logic bi;  // borrow in
  } csm_in_t;
endpackage

// File: rtl/csm_cell.sv
module csm_cell
  import div_pkg::*;
(
  input  csm_in_t in_i,
  input  logic    os_i,
  output logic    d_o,
  output logic    bo_o
);
  logic diff_raw;

  assign diff_raw = in_i.x ^ in_i.y ^ in_i.bi;
  assign d_o      = os_i ? in_i.x : diff_raw;
  assign bo_o     = (~in_i.x & in_i.y) | (in_i.bi & ~(in_i.x ^ in_i.y));
endmodule

// File: rtl/div_row.sv
module div_row
  import div_pkg::*;
#(
  parameter int Y_W = 4
) (
  input  logic [Y_W-1:0] prev_i,     // kept bits of previous partial remainder
  input  logic           dvd_bit_i,  // dividend bit entering this row
  input  logic [Y_W-1:0] divisor_i,
  output logic [Y_W:0]   diff_o,
  output logic           q_o
);
  localparam int NCOL = Y_W + 1;

  logic sel_w;  // row borrow: cancels the subtraction when set

  for (genvar j = 0; j < NCOL; j++) begin : g_col
    logic    xv, yv, biv, bo;
    csm_in_t cin;

    if (j == 0) begin : g_lsb
      assign xv  = dvd_bit_i;
      assign biv = 1'b0;
    end else begin : g_up
      assign xv  = prev_i[j-1];
      assign biv = g_col[j-1].bo;
    end

    if (j < Y_W) begin : g_sub
      assign yv = divisor_i[j];
    end else begin : g_top
      assign yv = 1'b0;
    end

    assign cin = '{x: xv, y: yv, bi: biv};

    csm_cell u_cell (
      .in_i (cin),
      .os_i (sel_w),
      .d_o  (diff_o[j]),
      .bo_o (bo)
    );
  end

  assign sel_w = g_col[Y_W].bo;
  assign q_o   = ~sel_w;
endmodule

// File: rtl/div_array.sv
module div_array #(
  parameter int X_W = 8,
  parameter int Y_W = 4
) (
  input  logic [X_W-1:0] dividend_i,
  input  logic [Y_W-1:0] divisor_i,
  output logic [X_W-1:0] quot_o,
  output logic [Y_W:0]   rem_o
);
  logic [X_W-2:0] drop_w;  // shifted-out top bits, zero for a nonzero divisor
  logic           unused_drop;

  for (genvar i = 0; i < X_W; i++) begin : g_row
    logic [Y_W:0]   diff;
    logic [Y_W-1:0] prev;
    logic           q;

    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = g_row[i-1].diff[Y_W-1:0];
    end

    div_row #(.Y_W(Y_W)) u_row (
      .prev_i    (prev),
      .dvd_bit_i (dividend_i[X_W-1-i]),
      .divisor_i (divisor_i),
      .diff_o    (diff),
      .q_o       (q)
    );

    assign quot_o[X_W-1-i] = q;

    if (i < X_W - 1) begin : g_drop
      assign drop_w[i] = diff[Y_W];
    end
  end

  assign rem_o       = g_row[X_W-1].diff;
  assign unused_drop = ^drop_w;
endmodule

// File: rtl/array_divider.sv
module array_divider #(
  parameter int X_W     = 8,
  parameter int Y_W     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [X_W-1:0] dividend_i,
  input  logic [Y_W-1:0] divisor_i,
  output logic [X_W-1:0] quotient_o,
  output logic [Y_W:0]   remainder_o
);
  logic [X_W-1:0] quot_w;
  logic [Y_W:0]   rem_w;

  div_array #(.X_W(X_W), .Y_W(Y_W)) u_array (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quot_o     (quot_w),
    .rem_o      (rem_w)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        quotient_o  <= '0;
        remainder_o <= '0;
      end else begin
        quotient_o  <= quot_w;
        remainder_o <= rem_w;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk_i ^ rst_ni;
    assign quotient_o  = quot_w;
    assign remainder_o = rem_w;
  end
endmodule

// File: rtl/array_divider_chk.sv
module array_divider_chk #(
  parameter int X_W     = 8,
  parameter int Y_W     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [X_W-1:0] dividend_i,
  input logic [Y_W-1:0] divisor_i,
  input logic [X_W-1:0] quotient_o,
  input logic [Y_W:0]   remainder_o
);
  localparam int W = X_W + Y_W + 1;

  logic           primed;
  logic [X_W-1:0] ref_dvd;
  logic [Y_W-1:0] ref_dsr;
  logic [X_W-1:0] exp_dvd;
  logic [Y_W-1:0] exp_dsr;
  logic           chk_on;
  logic [W-1:0]   recon;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed  <= 1'b0;
      ref_dvd <= '0;
      ref_dsr <= '0;
    end else begin
      primed  <= 1'b1;
      ref_dvd <= dividend_i;
      ref_dsr <= divisor_i;
    end
  end

  assign exp_dvd = REG_OUT ? ref_dvd : dividend_i;
  assign exp_dsr = REG_OUT ? ref_dsr : divisor_i;
  assign chk_on  = REG_OUT ? primed : 1'b1;
  assign recon   = W'(quotient_o) * W'(exp_dsr) + W'(remainder_o);

  // R1 with R2: quotient and remainder recombine to the dividend
  a_r1_recombine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_on && exp_dsr != '0) |-> (recon == W'(exp_dvd)));

  a_r2_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_on && exp_dsr != '0) |-> (remainder_o < (Y_W+1)'(exp_dsr)));

  a_r3_zero_div_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_on && exp_dsr == '0) |-> (quotient_o == '1));

  a_r4_zero_div_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_on && exp_dsr == '0) |-> (remainder_o == exp_dvd[Y_W:0]));

  if (REG_OUT) begin : g_rst_chk
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        a_r6_reset_clear: assert (quotient_o == '0 && remainder_o == '0);
      end
    end
  end
endmodule

bind array_divider array_divider_chk #(
  .X_W(X_W), .Y_W(Y_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/array_divider_test.sv
module array_divider_test;
  localparam int X_W = 8;
  localparam int Y_W = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b1;
  logic [X_W-1:0] dividend_i = '0;
  logic [Y_W-1:0] divisor_i = '0;
  logic [X_W-1:0] quotient_o;
  logic [Y_W:0]   remainder_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  array_divider #(.X_W(X_W), .Y_W(Y_W), .REG_OUT(1'b1)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (dvd=%0d dsr=%0d)",
               tag, got, exp, dividend_i, divisor_i);
    end
  endtask

  function automatic int exp_q(input int a, input int b);
    return (b == 0) ? (1 << X_W) - 1 : a / b;
  endfunction

  function automatic int exp_r(input int a, input int b);
    return (b == 0) ? (a & ((1 << (Y_W + 1)) - 1)) : a % b;
  endfunction

  // drive at a falling edge, result due after the next rising edge
  task automatic apply(input int a, input int b);
    @(negedge clk_i);
    dividend_i = X_W'(a);
    divisor_i  = Y_W'(b);
    @(negedge clk_i);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R6: reset state with nonzero operands present
    dividend_i = 8'd200;
    divisor_i  = 4'd7;
    #2 rst_ni = 1'b0;
    #1;
    chk("R6 reset quotient", int'(quotient_o), 0);
    chk("R6 reset remainder", int'(remainder_o), 0);
    repeat (2) @(negedge clk_i);
    chk("R6 reset held quotient", int'(quotient_o), 0);
    rst_ni = 1'b1;

    // R1 R2 R3 R4: exhaustive sweep
    for (int a = 0; a < (1 << X_W); a++) begin
      for (int b = 0; b < (1 << Y_W); b++) begin
        apply(a, b);
        if (b != 0) begin
          chk("R1 quotient", int'(quotient_o), exp_q(a, b));
          chk("R2 remainder", int'(remainder_o), exp_r(a, b));
        end else begin
          chk("R3 zero-divisor quotient", int'(quotient_o), exp_q(a, b));
          chk("R4 zero-divisor remainder", int'(remainder_o), exp_r(a, b));
        end
      end
    end

    // R7: dividend below divisor
    for (int b = 1; b < (1 << Y_W); b++) begin
      apply(b - 1, b);
      chk("R7 small quotient", int'(quotient_o), 0);
      chk("R7 small remainder", int'(remainder_o), b - 1);
    end

    // R5: an operand change between edges does not reach the outputs
    apply(255, 15);
    chk("R5 base quotient", int'(quotient_o), 17);
    dividend_i = 8'd100;
    divisor_i  = 4'd3;
    #1;
    chk("R5 hold quotient", int'(quotient_o), 17);
    chk("R5 hold remainder", int'(remainder_o), 0);
    @(negedge clk_i);
    chk("R5 update quotient", int'(quotient_o), 33);
    chk("R5 update remainder", int'(remainder_o), 1);

    // R6: asynchronous reset mid-run, then recovery
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    chk("R6 async quotient", int'(quotient_o), 0);
    chk("R6 async remainder", int'(remainder_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(250, 9);
    chk("R6 recovery quotient", int'(quotient_o), 27);
    chk("R6 recovery remainder", int'(remainder_o), 7);

    done = 1'b1;
    report();
    $finish;
  end
endmodule